// File: doc/BRIEF.md
# Polarity-Driven Inverter Gate Sequencer

This block produces the six gate commands for a single-stage buck-boost inverter. The inverter's output filter changes shape every half line cycle. A signed sample of the grid voltage goes to a polarity detector. The detector has a dead band around zero and needs the same sign on several consecutive samples before it accepts a polarity. The accepted polarity selects one of two legs. In the selected leg, a bidirectional filter-configuration switch and a line-frequency path switch are held on. The single high-frequency switch of that leg follows a carrier-based PWM. Every switch of the other leg is held off.

When the accepted polarity flips, all six gates are turned off for a fixed dead interval. They then stay off until the next carrier period begins, and the new leg starts there. The PWM compares a free-running carrier counter with a duty word. The duty word is captured only at the carrier wrap. An overcurrent trip input blanks every gate in the same cycle. Dropping the enable input turns all gates off and discards the detected polarity. With the default values, a 200 MHz clock gives a 20 kHz carrier (PERIOD = 10000). This carrier is intended for a 60 Hz grid.

Top module: `invGateSeq`

## Requirements
- R1: While reset is held, and after it is released with enable low, all six gate outputs are 0.
- R2: With positive polarity running, gSA and gS4 are 1, gS2, gS3 and gSB are 0, and gS1 carries the PWM.
- R3: With negative polarity running, gSB and gS3 are 1, gS1, gS4 and gSA are 0, and gS2 carries the PWM.
- R4: The carrier counts 0 to PERIOD-1 and wraps. The active high-frequency gate is 1 exactly when the carrier count is below the captured duty. Duty 0 keeps it off for the whole period. Duty of PERIOD or more keeps it on for the whole period.
- R5: A new duty word takes effect only at the first carrier count 0 after it is presented. A change made mid-period does not alter the remainder of that period.
- R6: A sample with value in [-HYST, HYST] votes for neither polarity and can never cause a polarity change.
- R7: A polarity is accepted only after DWELL consecutive samples have voted for it. Any shorter run of votes for it leaves the running pattern unchanged.
- R8: When a changed polarity is accepted while a leg runs, all six gates are 0 for DEAD_CYC cycles. They then stay 0 until the carrier is next at count 0, where the new leg begins. gSA and gSB are never 1 in adjacent cycles.
- R9: gSA and gSB are never 1 together, and gS1 and gS2 are never 1 together.
- R10: While trip is 1, all six gates are 0 in that same cycle. Running resumes when trip is released.
- R11: With enable low, all gates are 0 from the next cycle on, and the detected polarity is discarded. After enable returns, a fresh DWELL-long run is required. There is no dead interval, and the first leg starts at a carrier count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Sequencer enable |
| trip | input | 1 | Overcurrent trip, blanks all gates |
| gridV | input | V_W | Signed grid-voltage sample |
| duty | input | DUTY_W | PWM on-count per carrier period |
| gS1 | output | 1 | High-frequency switch, positive leg |
| gS2 | output | 1 | High-frequency switch, negative leg |
| gS3 | output | 1 | Line-frequency path switch, negative leg |
| gS4 | output | 1 | Line-frequency path switch, positive leg |
| gSA | output | 1 | Filter-configuration switch, positive leg |
| gSB | output | 1 | Filter-configuration switch, negative leg |

## Verification
The hardest situation to reach from the ports is a polarity that reverses again while the sequencer is still inside its dead interval, or while it waits for the carrier wrap. It is made harder by samples that dither across the dead band without ever completing a qualifying run. The bench uses a short carrier period, a short dwell and a short dead interval. It drives a fast triangular grid waveform, so reversals fall at every phase of the carrier. It also injects band-limited dither and runs of votes one sample short of the dwell. A behavioural model is compared with all six gates on every cycle.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

  typedef enum logic [1:0] {
    VOTE_NONE = 2'd0,
    VOTE_POS  = 2'd1,
    VOTE_NEG  = 2'd2
  } vote_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_DEAD = 2'd1,
    ST_WAIT = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_e;

  // strobes from the sequencing control to the PWM datapath
  typedef struct packed {
    logic run;
    logic polPos;
  } seq_strobe_t;

endpackage

// File: rtl/gsPolarityCtrl.sv
module gsPolarityCtrl
  import gate_seq_pkg::*;
#(
  parameter int V_W      = 16,
  parameter int HYST     = 64,
  parameter int DWELL    = 64,
  parameter int DEAD_CYC = 200
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic signed [V_W-1:0] gridV,
  input  logic                  periodEnd,
  output seq_strobe_t           strobes
);

  localparam int RUN_W  = $clog2(DWELL + 1);
  localparam int DEAD_W = $clog2(DEAD_CYC + 1);
  localparam logic signed [V_W-1:0] hystHi = HYST[V_W-1:0];
  localparam logic signed [V_W-1:0] hystLo = -hystHi;

  vote_e            vote, lastVote;
  logic [RUN_W-1:0] runCnt;
  logic             stable, votePos, flip;
  seq_state_e       state;
  logic             polPos;
  logic [DEAD_W-1:0] deadCnt;

  // sign vote with a dead band around zero
  always_comb begin
    if (gridV > hystHi)      vote = VOTE_POS;
    else if (gridV < hystLo) vote = VOTE_NEG;
    else                     vote = VOTE_NONE;
  end

  // length of the current run of identical votes, saturating at DWELL
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt   <= '0;
      lastVote <= VOTE_NONE;
    end else if (!enable || vote == VOTE_NONE) begin
      runCnt   <= '0;
      lastVote <= VOTE_NONE;
    end else if (vote == lastVote) begin
      if (!stable) runCnt <= runCnt + 1'b1;
    end else begin
      runCnt   <= RUN_W'(1);
      lastVote <= vote;
    end
  end

  assign stable  = (runCnt == RUN_W'(DWELL));
  assign votePos = (lastVote == VOTE_POS);
  assign flip    = stable && (votePos != polPos);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      polPos  <= 1'b0;
      deadCnt <= '0;
    end else if (!enable) begin
      state <= ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: if (stable) begin
          polPos <= votePos;
          state  <= ST_WAIT;
        end
        ST_RUN, ST_WAIT: begin
          if (flip) begin
            polPos  <= votePos;
            deadCnt <= '0;
            state   <= ST_DEAD;
          end else if (state == ST_WAIT && periodEnd) begin
            state <= ST_RUN;
          end
        end
        ST_DEAD: begin
          if (deadCnt == DEAD_W'(DEAD_CYC - 1)) state <= ST_WAIT;
          else deadCnt <= deadCnt + 1'b1;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  assign strobes.run    = (state == ST_RUN);
  assign strobes.polPos = polPos;

endmodule

// File: rtl/gsPwmPath.sv
module gsPwmPath
  import gate_seq_pkg::*;
#(
  parameter int PERIOD = 10000
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [$clog2(PERIOD + 1)-1:0]    duty,
  input  logic                             trip,
  input  seq_strobe_t                      strobes,
  output logic                             periodEnd,
  output logic [1:0]                       hfGate,
  output logic [1:0]                       legGate
);

  localparam int CNT_W  = $clog2(PERIOD);
  localparam int DUTY_W = $clog2(PERIOD + 1);

  logic [CNT_W-1:0]  carrier;
  logic [DUTY_W-1:0] dutyQ;
  logic              hfOn, allow;

  assign periodEnd = (carrier == CNT_W'(PERIOD - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carrier <= '0;
      dutyQ   <= '0;
    end else if (periodEnd) begin
      carrier <= '0;
      dutyQ   <= duty;
    end else begin
      carrier <= carrier + 1'b1;
    end
  end

  assign hfOn  = (DUTY_W'(carrier) < dutyQ);
  assign allow = strobes.run && !trip;

  // leg 0 serves the positive half cycle, leg 1 the negative one
  for (genvar leg = 0; leg < 2; leg++) begin : g_leg
    assign legGate[leg] = allow && (strobes.polPos == 1'(leg == 0));
    assign hfGate[leg]  = legGate[leg] && hfOn;
  end

endmodule

// File: rtl/invGateSeq.sv
module invGateSeq
  import gate_seq_pkg::*;
#(
  parameter int V_W      = 16,
  parameter int HYST     = 64,
  parameter int DWELL    = 64,
  parameter int DEAD_CYC = 200,
  parameter int PERIOD   = 10000,
  localparam int DUTY_W  = $clog2(PERIOD + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  trip,
  input  logic signed [V_W-1:0] gridV,
  input  logic [DUTY_W-1:0]     duty,
  output logic                  gS1,
  output logic                  gS2,
  output logic                  gS3,
  output logic                  gS4,
  output logic                  gSA,
  output logic                  gSB
);

  seq_strobe_t strobes;
  logic        periodEnd;
  logic [1:0]  hfGate, legGate;

  gsPolarityCtrl #(
    .V_W(V_W), .HYST(HYST), .DWELL(DWELL), .DEAD_CYC(DEAD_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .gridV(gridV),
    .periodEnd(periodEnd), .strobes(strobes)
  );

  gsPwmPath #(.PERIOD(PERIOD)) u_path (
    .clk(clk), .rstN(rstN), .duty(duty), .trip(trip), .strobes(strobes),
    .periodEnd(periodEnd), .hfGate(hfGate), .legGate(legGate)
  );

  assign gS1 = hfGate[0];
  assign gS2 = hfGate[1];
  assign gSA = legGate[0];
  assign gS4 = legGate[0];
  assign gSB = legGate[1];
  assign gS3 = legGate[1];

endmodule

// File: rtl/invGateSeqChk.sv
module invGateSeqChk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic trip,
  input logic gS1,
  input logic gS2,
  input logic gS3,
  input logic gS4,
  input logic gSA,
  input logic gSB
);

  AST_CFG_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(gSA && gSB)); // R9
  AST_HF_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(gS1 && gS2)); // R9
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rstN) gSA |-> (gS4 && !gS2 && !gS3)); // R2
  AST_NEG_HOLD: assert property (@(posedge clk) disable iff (!rstN) gSB |-> (gS3 && !gS1 && !gS4)); // R3
  AST_HF_POS_LEG: assert property (@(posedge clk) disable iff (!rstN) gS1 |-> gSA); // R2
  AST_TRIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    trip |-> !(gS1 || gS2 || gS3 || gS4 || gSA || gSB)); // R10
  AST_DEAD_GAP_A: assert property (@(posedge clk) disable iff (!rstN) gSA |=> !gSB); // R8
  AST_DEAD_GAP_B: assert property (@(posedge clk) disable iff (!rstN) gSB |=> !gSA); // R8
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !(gS1 || gS2 || gS3 || gS4 || gSA || gSB)); // R11

endmodule

bind invGateSeq invGateSeqChk u_chk (.*);

// File: tb/invGateSeq_bench.sv
`timescale 1ns/100ps
module invGateSeq_bench;

  localparam int VW = 12;
  localparam int H  = 100;
  localparam int DW = 3;
  localparam int DC = 4;
  localparam int P  = 8;
  localparam int DUW = $clog2(P + 1);

  logic clk = 1'b0;
  logic rstN, enable, trip;
  logic signed [VW-1:0] gridV;
  logic [DUW-1:0] duty;
  logic gS1, gS2, gS3, gS4, gSA, gSB;

  int testCnt = 0;
  int failCnt = 0;
  bit started = 1'b0;
  bit done = 1'b0;
  string curReq = "R1";

  // behavioural reference state
  int mCar = 0, mDuty = 0, mState = 0, mDead = 0;
  bit mPol = 1'b0;
  int hist[$];

  always #2.5 clk = ~clk;

  invGateSeq #(.V_W(VW), .HYST(H), .DWELL(DW), .DEAD_CYC(DC), .PERIOD(P)) u_invGateSeq (
    .clk(clk), .rstN(rstN), .enable(enable), .trip(trip), .gridV(gridV), .duty(duty),
    .gS1(gS1), .gS2(gS2), .gS3(gS3), .gS4(gS4), .gSA(gSA), .gSB(gSB)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCar = 0; mDuty = 0; mState = 0; mDead = 0; mPol = 1'b0;
      hist.delete();
    end else begin
      bit stab, sPos, pEnd;
      int v;
      stab = (hist.size() >= DW);
      sPos = stab && (hist[$] == 1);
      pEnd = (mCar == P - 1);
      if (!enable) mState = 0;
      else begin
        case (mState)
          0: if (stab) begin mPol = sPos; mState = 2; end
          1: if (mDead == DC - 1) mState = 2; else mDead++;
          default: begin
            if (stab && sPos != mPol) begin mPol = sPos; mDead = 0; mState = 1; end
            else if (mState == 2 && pEnd) mState = 3;
          end
        endcase
      end
      v = (gridV > H) ? 1 : ((gridV < -H) ? 2 : 0);
      if (!enable || v == 0) hist.delete();
      else begin
        if (hist.size() > 0 && hist[$] != v) hist.delete();
        hist.push_back(v);
        if (hist.size() > DW) void'(hist.pop_front());
      end
      if (pEnd) begin mCar = 0; mDuty = int'(duty); end
      else mCar++;
      started = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      logic [5:0] expV, actV;
      bit run, hf;
      #1;
      run = (mState == 3) && !trip;
      hf  = (mCar < mDuty);
      if (run && mPol)  expV = {hf, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
      else if (run)     expV = {1'b0, hf, 1'b1, 1'b0, 1'b0, 1'b1};
      else              expV = 6'b0;
      actV = {gS1, gS2, gS3, gS4, gSA, gSB};
      testCnt++;
      if (actV !== expV) begin
        failCnt++;
        $display("FAIL %s t=%0t gates{S1,S2,S3,S4,SA,SB} actual=%b expected=%b",
                 curReq, $time, actV, expV);
      end
    end
  end

  task automatic hold(int n, string req);
    curReq = req;
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog expired during %s", curReq);
      done = 1'b1;
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; trip = 1'b0; gridV = '0; duty = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    hold(6, "R1");
    // first detection and positive leg
    duty = 4'd3; enable = 1'b1; gridV = 12'sd500;
    hold(6, "R7");
    hold(30, "R2");
    hold(16, "R4");
    // duty change in the middle of a period
    @(negedge clk);
    duty = 4'd6;
    hold(24, "R5");
    // reversal to negative
    gridV = -12'sd500;
    hold(20, "R8");
    hold(30, "R3");
    // dither inside the dead band
    curReq = "R6";
    for (int i = 0; i < 40; i++) begin
      gridV = (i % 2 == 1) ? 12'sd60 : -12'sd90;
      @(negedge clk);
    end
    gridV = 12'sd100;
    hold(10, "R6");
    // run of opposite votes one short of the dwell
    gridV = 12'sd500;
    hold(DW - 1, "R7");
    gridV = 12'sd0;
    hold(12, "R7");
    gridV = 12'sd500;
    hold(30, "R8");
    // duty extremes
    duty = 4'd0;  hold(20, "R4");
    duty = 4'd8;  hold(20, "R4");
    duty = 4'd12; hold(20, "R4");
    duty = 4'd1;  hold(20, "R4");
    // trip
    duty = 4'd5;
    trip = 1'b1; hold(3, "R10");
    trip = 1'b0; hold(10, "R10");
    // enable drop and fresh detection
    enable = 1'b0; hold(6, "R11");
    enable = 1'b1; gridV = -12'sd500;
    hold(30, "R11");
    // fast triangular sweep with a trip pulse
    curReq = "R9";
    for (int k = 0; k < 600; k++) begin
      int t;
      t = k % 76;
      gridV = (t < 38) ? 12'(-760 + 40 * t) : 12'(760 - 40 * (t - 38));
      trip = (k == 300 || k == 301);
      duty = 4'((k / 50) % 10);
      @(negedge clk);
    end
    trip = 1'b0;
    hold(10, "R9");
    done = 1'b1;
    finishRun();
  end

endmodule